// File: doc/BRIEF.md
# Timer output flip-flop controller

This block owns the output flip-flop of a timer channel. A neighbouring 16-bit up-counter, with its comparators and capture registers, reports four kinds of event as single-cycle strobes. Two of these are matches against compare registers 0 and 1. The other two are loads of the counter value into capture registers 0 and 1. Each source can be enabled on its own to invert the output level. Software may also set, clear or invert the level directly through a two-bit command field.

The control byte is written and read through a plain register port. The command field acts only in the cycle of the write and always reads back as 11. Because of this, software must write the whole byte rather than modify a value it has read back. The reserved top pair of bits also reads as 11. Writing 11 in the command field changes only the enable bits, and the output keeps its level.

Top module: `tmr_outff_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, rd_data reads 8'hC3 (all event enables off) and ff_out is 0.
- R2: rd_data bits 1:0 and bits 7:6 always read 11, whatever was written there. Bits 5:2 return the enable bits from the most recent write, starting in the cycle after that write.
- R3: A write whose bits 1:0 are 01 makes ff_out 1 in the cycle after the write.
- R4: A write whose bits 1:0 are 10 makes ff_out 0 in the cycle after the write.
- R5: A write whose bits 1:0 are 00 inverts ff_out in the cycle after the write.
- R6: A write whose bits 1:0 are 11 leaves ff_out unchanged.
- R7: The enable bits map to ev_strobe as follows: bit 2 to ev_strobe[0] (compare 0 match), bit 3 to ev_strobe[1] (compare 1 match), bit 4 to ev_strobe[2] (capture 0 load) and bit 5 to ev_strobe[3] (capture 1 load). An enabled strobe inverts ff_out in the following cycle. A disabled strobe has no effect.
- R8: When several enabled strobes arrive in one cycle, ff_out inverts once per enabled strobe. An even count leaves ff_out as it was, and an odd count inverts it.
- R9: A set or clear command overrides any hardware events in the same cycle.
- R10: An invert command in the same cycle as enabled events adds one more inversion to the event count.
- R11: Events in a write cycle are gated by the enables held before that write. Newly written enables take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control byte to write |
| ev_strobe | input | 4 | Event strobes: [0] compare 0, [1] compare 1, [2] capture 0, [3] capture 1 |
| rd_data | output | 8 | Registered control byte view |
| ff_out | output | 1 | Flip-flop output level |

## Verification
A software command and hardware event strobes can fall in the same cycle. The bench drives writes with every command code together with every pattern of the four strobes, under changing enables, including writes that alter the enables in the very cycle the strobes arrive. A behavioural model decides each outcome from the requirements: set and clear override the strobes, an invert command adds one inversion to the event count, and the old enables gate the strobes. The model is compared against ff_out and rd_data on every clock.

// File: rtl/tof_pkg.sv
package tof_pkg;

  typedef enum logic [1:0] {
    CMD_INV = 2'b00,
    CMD_SET = 2'b01,
    CMD_CLR = 2'b10,
    CMD_NOP = 2'b11
  } sw_cmd_e;

  localparam int CMD_W  = 2;
  localparam int RSVD_W = 2;

endpackage

// File: rtl/tof_ctrl_reg.sv
module tof_ctrl_reg
  import tof_pkg::*;
#(
  parameter int NUM_EV = 4,
  localparam int REG_W = NUM_EV + CMD_W + RSVD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output sw_cmd_e           cmd,
  output logic [NUM_EV-1:0] en_q,
  output logic [REG_W-1:0]  rd_data
);

  localparam int EN_LSB = CMD_W;
  localparam int EN_MSB = CMD_W + NUM_EV - 1;

  logic unused_rsvd;
  assign unused_rsvd = ^wr_data[REG_W-1:EN_MSB+1];

  // the command exists only during the write cycle; otherwise no action
  always_comb begin
    cmd = CMD_NOP;
    if (wr_en) cmd = sw_cmd_e'(wr_data[CMD_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wr_data[EN_MSB:EN_LSB];
  end

  assign rd_data = {{RSVD_W{1'b1}}, en_q, {CMD_W{1'b1}}};

  a_r2_enables_follow_write : assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (en_q == $past(wr_data[EN_MSB:EN_LSB])));

  a_r2_enables_hold : assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(en_q));

endmodule

// File: rtl/tof_evt_parity.sv
module tof_evt_parity #(
  parameter int NUM_EV = 4
) (
  input  logic [NUM_EV-1:0] ev,
  input  logic [NUM_EV-1:0] en,
  output logic              flip
);

  logic [NUM_EV:0] chain;
  assign chain[0] = 1'b0;

  for (genvar i = 0; i < NUM_EV; i++) begin : g_src
    assign chain[i+1] = chain[i] ^ (ev[i] & en[i]);
  end

  assign flip = chain[NUM_EV];

endmodule

// File: rtl/tof_ff_core.sv
module tof_ff_core
  import tof_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  sw_cmd_e cmd,
  input  logic    ev_flip,
  output logic    q
);

  logic nxt;

  always_comb begin
    unique case (cmd)
      CMD_SET: nxt = 1'b1;
      CMD_CLR: nxt = 1'b0;
      CMD_INV: nxt = ~(q ^ ev_flip);
      default: nxt = q ^ ev_flip;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

  a_r3_set_wins : assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SET) |=> q);

  a_r4_clear_wins : assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLR) |=> !q);

endmodule

// File: rtl/tmr_outff_ctrl.sv
module tmr_outff_ctrl
  import tof_pkg::*;
#(
  parameter int NUM_EV = 4,
  localparam int REG_W = NUM_EV + CMD_W + RSVD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [NUM_EV-1:0] ev_strobe,
  output logic [REG_W-1:0]  rd_data,
  output logic              ff_out
);

  sw_cmd_e           cmd;
  logic [NUM_EV-1:0] en_q;
  logic              ev_flip;

  tof_ctrl_reg #(.NUM_EV(NUM_EV)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd),
    .en_q    (en_q),
    .rd_data (rd_data)
  );

  tof_evt_parity #(.NUM_EV(NUM_EV)) u_par (
    .ev   (ev_strobe),
    .en   (en_q),
    .flip (ev_flip)
  );

  tof_ff_core u_ff (
    .clk     (clk),
    .rst     (rst),
    .cmd     (cmd),
    .ev_flip (ev_flip),
    .q       (ff_out)
  );

  // R6: no-action write with no enabled strobe keeps the level
  a_r6_nop_keeps : assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[1:0] == 2'b11 && (ev_strobe & rd_data[CMD_W+NUM_EV-1:CMD_W]) == '0)
    |=> $stable(ff_out));

  // R8 / R11: without a write, the level changes by the parity of strobes gated by the held enables
  a_r8_event_parity : assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (ff_out == ($past(ff_out) ^ $past(^(ev_strobe & rd_data[CMD_W+NUM_EV-1:CMD_W])))));

  // R5: invert command with no enabled strobe flips the level
  a_r5_sw_invert : assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[1:0] == 2'b00 && (ev_strobe & rd_data[CMD_W+NUM_EV-1:CMD_W]) == '0)
    |=> (ff_out != $past(ff_out)));

  a_r2_fixed_fields : assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (rd_data[1:0] == 2'b11 && rd_data[REG_W-1:REG_W-2] == 2'b11));

endmodule

// File: tb/tb_tmr_outff_ctrl.sv
module tb_tmr_outff_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] ev_strobe = 4'h0;
  logic [7:0] rd_data;
  logic       ff_out;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference state
  bit [3:0] m_en = 4'h0;
  bit       m_ff = 1'b0;

  always #10 clk = ~clk;

  tmr_outff_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ev_strobe(ev_strobe), .rd_data(rd_data), .ff_out(ff_out)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic compare(input string req);
    bit [7:0] exp_rd;
    exp_rd = {2'b11, m_en, 2'b11};
    vectors++;
    if (rd_data !== exp_rd || ff_out !== m_ff) begin
      fails++;
      $display("FAIL %s: actual rd_data=%02h ff_out=%b expected rd_data=%02h ff_out=%b",
               req, rd_data, ff_out, exp_rd, m_ff);
    end
  endtask

  // drive one cycle of stimulus, advance the model, then check after the edge
  task automatic step(input bit w, input bit [7:0] d, input bit [3:0] ev, input string req);
    int hits;
    wr_en = w; wr_data = d; ev_strobe = ev;
    hits = 0;
    for (int i = 0; i < 4; i++) if (ev[i] && m_en[i]) hits++;
    if (w) begin
      case (d[1:0])
        2'b01: m_ff = 1'b1;
        2'b10: m_ff = 1'b0;
        2'b00: m_ff = m_ff ^ 1'b1 ^ hits[0];
        default: m_ff = m_ff ^ hits[0];
      endcase
      m_en = d[5:2];
    end else begin
      m_ff = m_ff ^ hits[0];
    end
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b1; wr_data = 8'hFD; ev_strobe = 4'hF;
    repeat (3) @(negedge clk);
    rst = 1'b0; wr_en = 1'b0; wr_data = 8'h00; ev_strobe = 4'h0;
    m_en = 4'h0; m_ff = 1'b0;
    compare("R1");
    step(0, 8'h00, 4'hF, "R1");        // strobes ignored, all enables off
    step(1, 8'hC1, 4'h0, "R3");        // set
    step(1, 8'hC2, 4'h0, "R4");        // clear
    step(1, 8'hC0, 4'h0, "R5");        // invert -> 1
    step(1, 8'hC0, 4'h0, "R5");        // invert -> 0
    step(1, 8'hC1, 4'h0, "R3");
    step(1, 8'hC3, 4'h0, "R6");        // no action, stays 1
    step(1, 8'h3F, 4'h0, "R2");        // reserved written 00, reads 11
    step(1, 8'h17, 4'h0, "R6");        // cmd 11, enables 0101
    step(1, 8'hC3, 4'h0, "R2");
    for (int i = 0; i < 4; i++) begin
      step(1, 8'hC3 | (8'h04 << i), 4'h0, "R7");
      step(0, 8'h00, 4'h1 << i, "R7");           // enabled: inverts
      step(0, 8'h00, ~(4'h1 << i), "R7");        // others disabled: no effect
    end
    step(1, 8'hFF, 4'h0, "R8");
    step(0, 8'h00, 4'h3, "R8");
    step(0, 8'h00, 4'h7, "R8");
    step(0, 8'h00, 4'hF, "R8");
    step(1, 8'hFD, 4'h1, "R9");        // set beats one event
    step(1, 8'hFE, 4'hF, "R9");        // clear beats all
    step(1, 8'hFC, 4'h1, "R10");       // invert + one event: unchanged
    step(1, 8'hFC, 4'h3, "R10");       // invert + two events: inverts
    step(1, 8'hC3, 4'h1, "R11");       // old enables gate: toggles
    step(0, 8'h00, 4'h1, "R11");       // new enables off: no toggle
    step(1, 8'hC7, 4'h1, "R11");       // enabling now does not count this strobe
    step(0, 8'h00, 4'h1, "R11");
    for (int n = 0; n < 3000; n++) begin
      bit w;
      bit [7:0] d;
      bit [3:0] ev;
      w = ($urandom_range(0, 2) == 0);
      d = 8'($urandom);
      ev = 4'($urandom);
      step(w, d, ev, "R8 R9 R10 R11");
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule